// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block brings a passive-matrix display panel up and down in a safe order. It drives two supply enables: one for the low-voltage logic supply and one for the high-voltage panel drive supply. It also drives the panel's active-low reset line. It asks an external command sender for four operations, each selected by a two-bit code: display off, run the initialisation list, fill the screen with a clear pattern, and display on. The sender acknowledges each operation with a one-cycle done pulse. The byte stream behind each operation is the sender's concern.

The two settling waits use a counter whose length comes from a clock-frequency parameter (in kHz) and a millisecond parameter. One wait runs after the drive supply comes up and before display on. The other runs after the drive supply drops and before the logic supply drops. A recover input restarts the panel while it is running. The restart pulses reset and replays the bring-up commands, and the drive supply is left as it is. A power-off request that arrives part way through bring-up is held until the current step finishes. The controller then turns to the shut-down path.

Top module: `disp_pwr_seq`

## Requirements
- R1: Synchronous reset (`rst` high) forces `logic_en`, `hv_en`, `panel_rst_n`, `cmd_req`, `panel_on` and `busy` low. `busy` is also low whenever the controller sits idle.
- R2: A one-cycle `pwr_on_req` while idle raises `logic_en`. In the same cycle `panel_rst_n` goes low for exactly RST_CYCLES cycles. `cmd_req` is never high while `panel_rst_n` is low, and `busy` is high during bring-up.
- R3: After the reset pulse, commands are requested in the order display off (`cmd_op`=0), initialise (1), clear (2). Each request holds `cmd_req` high with a stable `cmd_op` until a `cmd_done` pulse arrives.
- R4: `hv_en` rises only in the cycle after the clear command is acknowledged. It is never high without `logic_en`, and never rises before a display-off command has been acknowledged since the last panel reset.
- R5: Display on (`cmd_op`=3) is requested exactly SETTLE cycles after `hv_en` rises, where SETTLE = CLK_KHZ*SETTLE_MS. `panel_on` goes high once that request is acknowledged, and only while both supplies are on.
- R6: A `pwr_off_req` while running first requests display off (0) with `hv_en` still high. After the acknowledgement `hv_en` falls. `logic_en` and `panel_rst_n` fall exactly SETTLE cycles later.
- R7: A `pwr_off_req` during a bring-up command leaves that command requested until it is acknowledged. A display-off request (0) follows. If `hv_en` never rose, `logic_en` falls in the cycle after that acknowledgement.
- R8: A `pwr_off_req` during the drive-supply settling wait requests display off (0) on the next cycle. The drain wait from R6 follows its acknowledgement.
- R9: A `recover` pulse while running lowers `panel_on` and pulses `panel_rst_n` low for RST_CYCLES cycles. It then replays commands 0, 1 and 2. `hv_en` and `logic_en` stay high throughout, and display on (3) is requested in the cycle after the clear acknowledgement, with no settling wait.
- R10: A `cmd_done` while no command is requested, or a `pwr_on_req` while running, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Request panel bring-up (taken while idle) |
| pwr_off_req | input | 1 | Request panel shut-down |
| recover | input | 1 | Restart the panel while running, drive supply untouched |
| cmd_done | input | 1 | One-cycle acknowledgement from the command sender |
| logic_en | output | 1 | Logic / I/O supply enable |
| hv_en | output | 1 | High-voltage panel drive supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_op | output | 2 | Command code: 0 off, 1 init, 2 clear, 3 on |
| panel_on | output | 1 | Panel running with display on |
| busy | output | 1 | A bring-up, restart or shut-down is in progress |

## Verification
The assertions check the safety interlocks on every cycle:
- the drive supply never outlives the logic supply;
- the drive supply rises only after an acknowledged display-off;
- no command is requested while the panel is held in reset;
- a request and its code hold until acknowledged;
- display on and the logic-supply drop never come before the full settling count.

Only the bench scenarios can show the rest. These are the exact command order, the exact pulse and wait lengths, how a pending power-off is taken at each point of bring-up, the restart path that skips the wait, and that stray acknowledgements and power-on requests are ignored.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RESET,
    S_SEND_OFF,
    S_SEND_INIT,
    S_SEND_CLR,
    S_HV_SETTLE,
    S_SEND_ON,
    S_RUN,
    S_DOWN_OFF,
    S_HV_DRAIN
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_DISP_OFF = 2'd0,
    OP_INIT     = 2'd1,
    OP_CLEAR    = 2'd2,
    OP_DISP_ON  = 2'd3
  } cmd_op_e;

  function automatic logic is_cmd_state(input seq_state_e s);
    return (s == S_SEND_OFF) || (s == S_SEND_INIT) || (s == S_SEND_CLR) ||
           (s == S_SEND_ON)  || (s == S_DOWN_OFF);
  endfunction

  function automatic cmd_op_e op_for_state(input seq_state_e s);
    case (s)
      S_SEND_INIT: return OP_INIT;
      S_SEND_CLR:  return OP_CLEAR;
      S_SEND_ON:   return OP_DISP_ON;
      default:     return OP_DISP_OFF;
    endcase
  endfunction

  function automatic logic is_timed_state(input seq_state_e s);
    return (s == S_RESET) || (s == S_HV_SETTLE) || (s == S_HV_DRAIN);
  endfunction

endpackage

// File: rtl/dps_sticky_flag.sv
module dps_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

endmodule

// File: rtl/dps_seq_timer.sv
module dps_seq_timer #(
  parameter int unsigned SHORT_CYC = 16,
  parameter int unsigned LONG_CYC  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic long_i,
  output logic done_o
);

  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  generate
    if (SHORT_CYC == LONG_CYC) begin : g_one_len
      assign last = LONG_LAST;
    end else begin : g_two_len
      assign last = long_i ? LONG_LAST : SHORT_LAST;
    end
  endgenerate

  assign done_o = run_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dps_seq_fsm.sv
module dps_seq_fsm
  import dps_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    on_req_i,
  input  logic    off_pend_i,
  input  logic    recover_i,
  input  logic    cmd_done_i,
  input  logic    tmr_done_i,
  output logic    tmr_run_o,
  output logic    tmr_long_o,
  output logic    off_clr_o,
  output logic    logic_en_o,
  output logic    hv_en_o,
  output logic    panel_rst_n_o,
  output logic    cmd_req_o,
  output cmd_op_e cmd_op_o,
  output logic    panel_on_o,
  output logic    busy_o
);

  seq_state_e state_q, state_d;
  logic       hv_d;
  logic       ack;

  assign ack        = is_cmd_state(state_q) && cmd_done_i;
  assign tmr_run_o  = is_timed_state(state_q);
  assign tmr_long_o = (state_q != S_RESET);
  assign off_clr_o  = (state_q == S_IDLE) || (state_q == S_DOWN_OFF);

  always_comb begin
    state_d = state_q;
    hv_d    = hv_en_o;
    unique case (state_q)
      S_IDLE: begin
        if (on_req_i && !off_pend_i) state_d = S_RESET;
      end
      S_RESET: begin
        if (tmr_done_i) state_d = off_pend_i ? S_DOWN_OFF : S_SEND_OFF;
      end
      S_SEND_OFF: begin
        if (ack) state_d = off_pend_i ? S_DOWN_OFF : S_SEND_INIT;
      end
      S_SEND_INIT: begin
        if (ack) state_d = off_pend_i ? S_DOWN_OFF : S_SEND_CLR;
      end
      S_SEND_CLR: begin
        if (ack) begin
          if (off_pend_i)   state_d = S_DOWN_OFF;
          else if (hv_en_o) state_d = S_SEND_ON;
          else begin
            state_d = S_HV_SETTLE;
            hv_d    = 1'b1;
          end
        end
      end
      S_HV_SETTLE: begin
        if (off_pend_i)      state_d = S_DOWN_OFF;
        else if (tmr_done_i) state_d = S_SEND_ON;
      end
      S_SEND_ON: begin
        if (ack) state_d = off_pend_i ? S_DOWN_OFF : S_RUN;
      end
      S_RUN: begin
        if (off_pend_i)     state_d = S_DOWN_OFF;
        else if (recover_i) state_d = S_RESET;
      end
      S_DOWN_OFF: begin
        if (ack) begin
          if (hv_en_o) begin
            state_d = S_HV_DRAIN;
            hv_d    = 1'b0;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_HV_DRAIN: begin
        if (tmr_done_i) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
    if (state_d == S_IDLE) hv_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      hv_en_o       <= 1'b0;
      logic_en_o    <= 1'b0;
      panel_rst_n_o <= 1'b0;
      cmd_req_o     <= 1'b0;
      cmd_op_o      <= OP_DISP_OFF;
      panel_on_o    <= 1'b0;
      busy_o        <= 1'b0;
    end else begin
      state_q       <= state_d;
      hv_en_o       <= hv_d;
      logic_en_o    <= (state_d != S_IDLE);
      panel_rst_n_o <= (state_d != S_IDLE) && (state_d != S_RESET);
      cmd_req_o     <= is_cmd_state(state_d);
      cmd_op_o      <= op_for_state(state_d);
      panel_on_o    <= (state_d == S_RUN);
      busy_o        <= (state_d != S_IDLE) && (state_d != S_RUN);
    end
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned SETTLE_MS  = 100,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic       recover,
  input  logic       cmd_done,
  output logic       logic_en,
  output logic       hv_en,
  output logic       panel_rst_n,
  output logic       cmd_req,
  output logic [1:0] cmd_op,
  output logic       panel_on,
  output logic       busy
);

  localparam int unsigned SETTLE_CYC = CLK_KHZ * SETTLE_MS;

  logic    off_pend_q, off_clr, off_pend;
  logic    tmr_run, tmr_long, tmr_done;
  cmd_op_e op_e;

  assign off_pend = off_pend_q | pwr_off_req;
  assign cmd_op   = op_e;

  dps_sticky_flag u_off_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (pwr_off_req),
    .clr_i  (off_clr),
    .flag_o (off_pend_q)
  );

  dps_seq_timer #(
    .SHORT_CYC (RST_CYCLES),
    .LONG_CYC  (SETTLE_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (tmr_run),
    .long_i (tmr_long),
    .done_o (tmr_done)
  );

  dps_seq_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .on_req_i      (pwr_on_req),
    .off_pend_i    (off_pend),
    .recover_i     (recover),
    .cmd_done_i    (cmd_done),
    .tmr_done_i    (tmr_done),
    .tmr_run_o     (tmr_run),
    .tmr_long_o    (tmr_long),
    .off_clr_o     (off_clr),
    .logic_en_o    (logic_en),
    .hv_en_o       (hv_en),
    .panel_rst_n_o (panel_rst_n),
    .cmd_req_o     (cmd_req),
    .cmd_op_o      (op_e),
    .panel_on_o    (panel_on),
    .busy_o        (busy)
  );

endmodule

// File: rtl/dps_seq_chk.sv
module dps_seq_chk #(
  parameter int unsigned SETTLE_CYC = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_done,
  input logic       logic_en,
  input logic       hv_en,
  input logic       panel_rst_n,
  input logic       cmd_req,
  input logic [1:0] cmd_op,
  input logic       panel_on
);

  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(SETTLE_CYC);

  logic [CW-1:0] hv_on_cnt, hv_off_cnt;
  logic          off_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hv_on_cnt  <= '0;
      hv_off_cnt <= SAT;
      off_seen_q <= 1'b0;
    end else begin
      hv_on_cnt  <= !hv_en ? '0 : ((hv_on_cnt == SAT) ? SAT : hv_on_cnt + 1'b1);
      hv_off_cnt <= hv_en ? '0 : ((hv_off_cnt == SAT) ? SAT : hv_off_cnt + 1'b1);
      if (!panel_rst_n)                                   off_seen_q <= 1'b0;
      else if (cmd_req && cmd_op == 2'd0 && cmd_done)     off_seen_q <= 1'b1;
    end
  end

  // R4
  hv_needs_logic_chk: assert property (@(posedge clk) disable iff (rst)
    hv_en |-> logic_en);

  // R4
  hv_after_off_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_en) |-> off_seen_q);

  // R2
  no_cmd_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> (panel_rst_n && logic_en));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_op)));

  // R5
  settle_before_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && cmd_op == 2'd3) |-> (hv_on_cnt >= SAT));

  // R5
  on_flag_supplies_chk: assert property (@(posedge clk) disable iff (rst)
    panel_on |-> (hv_en && logic_en));

  // R6
  drain_before_logic_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(logic_en) |-> (hv_off_cnt >= SAT));

endmodule

bind disp_pwr_seq dps_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_done    (cmd_done),
  .logic_en    (logic_en),
  .hv_en       (hv_en),
  .panel_rst_n (panel_rst_n),
  .cmd_req     (cmd_req),
  .cmd_op      (cmd_op),
  .panel_on    (panel_on)
);

// File: tb/sim_disp_pwr_seq.sv
`timescale 1ns/1ps
module sim_disp_pwr_seq;

  localparam int CLK_KHZ = 1;
  localparam int SETTLE_MS = 100;
  localparam int RST_CYC = 4;
  localparam int SETTLE = CLK_KHZ * SETTLE_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, recover = 1'b0, cmd_done = 1'b0;
  logic logic_en, hv_en, panel_rst_n, cmd_req, panel_on, busy;
  logic [1:0] cmd_op;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  disp_pwr_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_MS(SETTLE_MS), .RST_CYCLES(RST_CYC)) u0 (
    .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .recover(recover), .cmd_done(cmd_done), .logic_en(logic_en), .hv_en(hv_en),
    .panel_rst_n(panel_rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .panel_on(panel_on), .busy(busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ack(input int op, input string req);
    int n = 0;
    while (!cmd_req && n < 1000) begin n++; tick(); end
    chk(req, "cmd_req present", int'(cmd_req), 1);
    chk(req, "cmd_op", int'(cmd_op), op);
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
  endtask

  task automatic count_rst_low(input string req);
    int n = 0;
    while (!panel_rst_n && n < 1000) begin
      if (cmd_req) chk(req, "cmd_req during reset", 1, 0);
      n++; tick();
    end
    chk(req, "reset pulse length", n, RST_CYC);
  endtask

  task automatic start_up_to_clear();
    pwr_on_req = 1'b1; tick(); pwr_on_req = 1'b0;
    chk("R2", "logic_en up", int'(logic_en), 1);
    chk("R2", "panel_rst_n low", int'(panel_rst_n), 0);
    chk("R2", "busy in bring-up", int'(busy), 1);
    count_rst_low("R2");
    chk("R4", "hv before off cmd", int'(hv_en), 0);
    ack(0, "R3");
    chk("R4", "hv before init", int'(hv_en), 0);
    ack(1, "R3");
    chk("R4", "hv before clear", int'(hv_en), 0);
    ack(2, "R3");
  endtask

  task automatic full_power_up();
    int n = 0;
    start_up_to_clear();
    chk("R4", "hv after clear ack", int'(hv_en), 1);
    while (hv_en && !cmd_req && n < 10000) begin n++; tick(); end
    chk("R5", "settle length", n, SETTLE);
    ack(3, "R5");
    chk("R5", "panel_on", int'(panel_on), 1);
    chk("R1", "busy low when running", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "logic_en", int'(logic_en), 0);
    chk("R1", "hv_en", int'(hv_en), 0);
    chk("R1", "panel_rst_n", int'(panel_rst_n), 0);
    chk("R1", "cmd_req", int'(cmd_req), 0);
    chk("R1", "panel_on", int'(panel_on), 0);
    chk("R1", "busy", int'(busy), 0);
  endtask

  task automatic t_ignore();
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
    pwr_on_req = 1'b1; tick(); pwr_on_req = 1'b0;
    tick();
    chk("R10", "panel_on kept", int'(panel_on), 1);
    chk("R10", "no cmd_req", int'(cmd_req), 0);
    chk("R10", "panel_rst_n kept", int'(panel_rst_n), 1);
    chk("R10", "hv kept", int'(hv_en), 1);
    chk("R10", "busy kept low", int'(busy), 0);
  endtask

  task automatic t_recover();
    recover = 1'b1; tick(); recover = 1'b0;
    chk("R9", "panel_on dropped", int'(panel_on), 0);
    chk("R9", "panel_rst_n low", int'(panel_rst_n), 0);
    chk("R9", "hv kept", int'(hv_en), 1);
    chk("R9", "logic kept", int'(logic_en), 1);
    count_rst_low("R9");
    ack(0, "R9");
    chk("R9", "hv during replay", int'(hv_en), 1);
    ack(1, "R9");
    ack(2, "R9");
    chk("R9", "on request at once", int'(cmd_req), 1);
    chk("R9", "on code at once", int'(cmd_op), 3);
    ack(3, "R9");
    chk("R9", "panel_on again", int'(panel_on), 1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    chk(req, "hv dropped after off ack", int'(hv_en), 0);
    while (logic_en && !hv_en && n < 10000) begin n++; tick(); end
    chk(req, "drain length", n, SETTLE);
    chk(req, "logic_en off", int'(logic_en), 0);
    chk(req, "panel_rst_n low", int'(panel_rst_n), 0);
    chk("R1", "busy low idle", int'(busy), 0);
  endtask

  task automatic t_power_down();
    pwr_off_req = 1'b1; tick(); pwr_off_req = 1'b0;
    chk("R6", "panel_on dropped", int'(panel_on), 0);
    chk("R6", "hv still on", int'(hv_en), 1);
    ack(0, "R6");
    drain("R6");
  endtask

  task automatic t_abort_cmd();
    pwr_on_req = 1'b1; tick(); pwr_on_req = 1'b0;
    count_rst_low("R7");
    ack(0, "R7");
    pwr_off_req = 1'b1; tick(); pwr_off_req = 1'b0;
    tick(); tick();
    chk("R7", "init still requested", int'(cmd_req), 1);
    chk("R7", "init code kept", int'(cmd_op), 1);
    ack(1, "R7");
    chk("R7", "off requested next", int'(cmd_req), 1);
    chk("R7", "off code", int'(cmd_op), 0);
    chk("R7", "hv never on", int'(hv_en), 0);
    ack(0, "R7");
    chk("R7", "logic off at once", int'(logic_en), 0);
  endtask

  task automatic t_abort_settle();
    start_up_to_clear();
    repeat (5) tick();
    pwr_off_req = 1'b1; tick(); pwr_off_req = 1'b0;
    chk("R8", "off requested", int'(cmd_req), 1);
    chk("R8", "off code", int'(cmd_op), 0);
    chk("R8", "hv still on", int'(hv_en), 1);
    ack(0, "R8");
    drain("R8");
  endtask

  task automatic t_reset_mid_run();
    full_power_up();
    rst = 1'b1; tick(); rst = 1'b0; tick();
    t_reset();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    full_power_up();
    t_ignore();
    t_recover();
    t_power_down();
    t_abort_cmd();
    tick();
    t_abort_settle();
    tick();
    t_reset_mid_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule